// File: doc/BRIEF.md
# Cursor-Aware Row Scan Multiplexer

This block refreshes a row of four 5-by-7 dot-matrix character cells, lighting one pixel row at a time. In the dark interval before each row it walks the digits one per cycle. For each digit it reads the character code through a small read port and looks up the five column bits for the current row through a combinational font port. It latches each digit's pattern into a shadow register. When the next refresh tick arrives, that row is lit: one row-select line goes high and 20 column lines carry the shadow patterns.

A global cursor-enable input replaces the looked-up pattern with a solid block at every digit whose cursor bit is set. The block is shown only on alternate frames, which gives half brightness. Toggling the enable from outside flashes the cursor. Per-digit enables from a separate blanking controller gate the column lines directly. Blanking therefore never touches the shadow registers, the character store or the font path. The refresh rate comes from a runtime divider input.

Top module: `dsm_scan_mux`

## Requirements
- R1: During reset and until the first refresh tick after reset, `row_sel` and `col_out` are all zero. The first row lit after reset is row 0.
- R2: Rows are lit in the order 0, 1, …, 6 and then wrap to 0. While row r is lit, `row_sel` has only bit r set.
- R3: Each lit row is followed by one dark slot in which `row_sel` is zero and every `col_out` bit is zero. One lit row never changes directly into another.
- R4: Every slot, lit or dark, lasts `refresh_div`+1 clock cycles. `refresh_div` must be at least 4, the number of digits, so that the fetch finishes inside the dark slot.
- R5: Font bit i of digit d appears on `col_out[5*d+i]`. Digit 0 is the rightmost character and digit 3 the leftmost. The font is queried with the digit's code and the row number being fetched.
- R6: With `cursor_en`=0, every enabled digit shows its character pattern whatever the value of `cursor_bits`.
- R7: With `cursor_en`=1, a digit whose `cursor_bits[d]`=1 shows all five columns on (5'b11111) in every row of an odd-numbered frame and all columns off in an even-numbered frame. The other digits show their characters.
- R8: The cursor phase flips exactly once per complete 7-row frame. The first frame after reset is frame 0, an even frame.
- R9: `digit_en[d]`=0 forces digit d's five columns to zero at once. When the enable is raised again within the same row, the stored pattern reappears unchanged.
- R10: Character codes, cursor inputs and font data are sampled only in the dark slot that precedes the row. A code change while a row is lit leaves that row's columns unchanged and takes effect in the next row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_div | input | 16 | Slot length minus one, in clock cycles |
| cursor_en | input | 1 | Global cursor display enable |
| cursor_bits | input | 4 | Per-digit cursor flags |
| digit_en | input | 4 | Per-digit column enable from the blanking controller |
| code_addr | output | 2 | Digit index being fetched |
| code_data | input | 7 | Character code of digit `code_addr` |
| font_code | output | 7 | Code presented to the font lookup |
| font_row | output | 3 | Row presented to the font lookup |
| font_cols | input | 5 | Column bits returned by the font lookup |
| row_sel | output | 7 | One-hot row drive, zero in dark slots |
| col_out | output | 20 | Column drive, five bits per digit |

## Verification
The bench checks whole frames. It compares every lit row with a stub font, and it checks that each dark slot has zero columns. A design that fetched with the old row number, or that skipped the dark slot, would show shifted glyphs or ghost columns there. The cursor test runs two frames back to back and requires the cursor columns to be fully on in one and fully off in the other. A phase that flips per row or never flips fails that check.

The bench also toggles a digit enable during a lit row and expects the pattern to return, which catches gating applied at the shadow load. It changes a character code mid-row and expects no change until the next row, which catches a combinational path from the code to the columns. The divider is run at its minimum legal value of 4, where a fetch longer than four cycles would light a stale digit 3.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
   typedef enum logic {
      SLOT_DARK = 1'b0,
      SLOT_LIT  = 1'b1
   } slot_e;
endpackage

// File: rtl/dsm_prescaler.sv
module dsm_prescaler #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);
   logic [PRE_W-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dsm_row_seq.sv
module dsm_row_seq
   import dsm_pkg::*;
#(
   parameter int ROWS       = 7,
   parameter int NUM_DIGITS = 4,
   localparam int ROW_W     = $clog2(ROWS),
   localparam int DIG_W     = $clog2(NUM_DIGITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output slot_e            slot,
   output logic [ROW_W-1:0] row_idx,
   output logic             busy,
   output logic [DIG_W-1:0] dig,
   output logic             phase
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot    <= SLOT_DARK;
         row_idx <= '0;
         busy    <= 1'b1;
         dig     <= '0;
         phase   <= 1'b0;
      end else begin
         if (busy) begin
            if (dig == DIG_W'(NUM_DIGITS-1)) busy <= 1'b0;
            else                             dig  <= dig + 1'b1;
         end
         if (tick) begin
            if (slot == SLOT_DARK) begin
               slot <= SLOT_LIT;
            end else begin
               slot <= SLOT_DARK;
               busy <= 1'b1;
               dig  <= '0;
               if (row_idx == ROW_W'(ROWS-1)) begin
                  row_idx <= '0;
                  phase   <= ~phase;
               end else begin
                  row_idx <= row_idx + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dsm_fetch.sv
module dsm_fetch #(
   parameter int NUM_DIGITS = 4,
   parameter int COLS       = 5,
   localparam int DIG_W     = $clog2(NUM_DIGITS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       busy,
   input  logic [DIG_W-1:0]           dig,
   input  logic                       phase,
   input  logic                       cursor_en,
   input  logic [NUM_DIGITS-1:0]      cursor_bits,
   input  logic [COLS-1:0]            font_cols,
   output logic [NUM_DIGITS*COLS-1:0] shadow
);
   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
      logic [COLS-1:0] pick;
      assign pick = (cursor_en && cursor_bits[d]) ? {COLS{phase}} : font_cols;

      always_ff @(posedge clk) begin
         if (!rst_n)
            shadow[d*COLS +: COLS] <= '0;
         else if (busy && (dig == DIG_W'(d)))
            shadow[d*COLS +: COLS] <= pick;
      end
   end
endmodule

// File: rtl/dsm_scan_mux.sv
module dsm_scan_mux
   import dsm_pkg::*;
#(
   parameter int NUM_DIGITS = 4,
   parameter int COLS       = 5,
   parameter int ROWS       = 7,
   parameter int CODE_W     = 7,
   parameter int PRE_W      = 16,
   localparam int ROW_W     = $clog2(ROWS),
   localparam int DIG_W     = $clog2(NUM_DIGITS),
   localparam int OUT_W     = NUM_DIGITS * COLS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PRE_W-1:0]      refresh_div,
   input  logic                  cursor_en,
   input  logic [NUM_DIGITS-1:0] cursor_bits,
   input  logic [NUM_DIGITS-1:0] digit_en,
   output logic [DIG_W-1:0]      code_addr,
   input  logic [CODE_W-1:0]     code_data,
   output logic [CODE_W-1:0]     font_code,
   output logic [ROW_W-1:0]      font_row,
   input  logic [COLS-1:0]       font_cols,
   output logic [ROWS-1:0]       row_sel,
   output logic [OUT_W-1:0]      col_out
);
   if (NUM_DIGITS < 2) begin : g_bad_digits
      $error("dsm_scan_mux: NUM_DIGITS must be at least 2");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("dsm_scan_mux: ROWS must be at least 2");
   end
   if (COLS < 1 || CODE_W < 1) begin : g_bad_width
      $error("dsm_scan_mux: COLS and CODE_W must be positive");
   end
   if (PRE_W < $clog2(NUM_DIGITS + 1)) begin : g_bad_pre
      $error("dsm_scan_mux: PRE_W too narrow for the minimum divider");
   end

   logic             tick;
   slot_e            slot;
   logic [ROW_W-1:0] row_idx;
   logic             fetch_busy;
   logic [DIG_W-1:0] fetch_dig;
   logic             phase;
   logic [OUT_W-1:0] shadow;
   logic             lit;

   dsm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (refresh_div),
      .tick (tick)
   );

   dsm_row_seq #(.ROWS(ROWS), .NUM_DIGITS(NUM_DIGITS)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .slot   (slot),
      .row_idx(row_idx),
      .busy   (fetch_busy),
      .dig    (fetch_dig),
      .phase  (phase)
   );

   dsm_fetch #(.NUM_DIGITS(NUM_DIGITS), .COLS(COLS)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (fetch_busy),
      .dig        (fetch_dig),
      .phase      (phase),
      .cursor_en  (cursor_en),
      .cursor_bits(cursor_bits),
      .font_cols  (font_cols),
      .shadow     (shadow)
   );

   assign code_addr = fetch_dig;
   assign font_code = code_data;
   assign font_row  = row_idx;
   assign lit       = (slot == SLOT_LIT);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_sel[r] = lit && (row_idx == ROW_W'(r));
   end

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_col
      assign col_out[d*COLS +: COLS] = shadow[d*COLS +: COLS] & {COLS{lit & digit_en[d]}};
   end
endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
   parameter int NUM_DIGITS = 4,
   parameter int COLS       = 5,
   parameter int ROWS       = 7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ROWS-1:0]            row_sel,
   input logic [NUM_DIGITS*COLS-1:0] col_out,
   input logic [NUM_DIGITS-1:0]      digit_en,
   input logic                       busy
);
   logic [NUM_DIGITS*COLS-1:0] en_mask;
   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_mask
      assign en_mask[d*COLS +: COLS] = {COLS{digit_en[d]}};
   end

   AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_sel)); // R2
   AST_DARK_COLS: assert property (@(posedge clk) disable iff (!rst_n)
      (row_sel == '0) |-> (col_out == '0)); // R3
   AST_NO_ROW_HOP: assert property (@(posedge clk) disable iff (!rst_n)
      (row_sel != '0) |=> ((row_sel == '0) || $stable(row_sel))); // R3
   AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(row_sel != '0) |-> !busy); // R10
   AST_BLANK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ((col_out & ~en_mask) == '0)); // R9
endmodule

bind dsm_scan_mux dsm_checker #(
   .NUM_DIGITS(NUM_DIGITS),
   .COLS      (COLS),
   .ROWS      (ROWS)
) u_dsm_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .row_sel (row_sel),
   .col_out (col_out),
   .digit_en(digit_en),
   .busy    (fetch_busy)
);

// File: tb/test_dsm_scan_mux.sv
module test_dsm_scan_mux;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 4, NC = 5, NR = 7, CW = 7, PW = 16;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic             rst_n;
   logic [PW-1:0]    refresh_div;
   logic             cursor_en;
   logic [ND-1:0]    cursor_bits;
   logic [ND-1:0]    digit_en;
   logic [1:0]       code_addr;
   logic [CW-1:0]    code_data;
   logic [CW-1:0]    font_code;
   logic [2:0]       font_row;
   logic [NC-1:0]    font_cols;
   logic [NR-1:0]    row_sel;
   logic [ND*NC-1:0] col_out;
   logic [CW-1:0]    chars [ND];

   int checks = 0, errors = 0, frames = 0;
   logic [NR-1:0] prev_rs = '0;
   bit done = 1'b0;

   function automatic logic [NC-1:0] glyph(input logic [CW-1:0] c, input logic [2:0] r);
      return c[4:0] ^ {r, r[1:0]} ^ {4'b0, c[6]};
   endfunction

   assign code_data = chars[code_addr];
   assign font_cols = glyph(font_code, font_row);

   dsm_scan_mux i_dsm_scan_mux (
      .clk(clk), .rst_n(rst_n), .refresh_div(refresh_div), .cursor_en(cursor_en),
      .cursor_bits(cursor_bits), .digit_en(digit_en), .code_addr(code_addr),
      .code_data(code_data), .font_code(font_code), .font_row(font_row),
      .font_cols(font_cols), .row_sel(row_sel), .col_out(col_out)
   );

   // frame counter from the ports: a new frame starts when row 0 lights
   always @(negedge clk) begin
      if (!rst_n) begin
         frames  = 0;
         prev_rs = '0;
      end else begin
         if (row_sel == 7'h01 && prev_rs == '0) frames++;
         prev_rs = row_sel;
      end
   end

   function automatic logic [ND*NC-1:0] exp_cols(input int r);
      logic [ND*NC-1:0] e;
      logic ph;
      ph = frames[0] ? 1'b0 : 1'b1;  // frame 1 (first) is even phase
      for (int d = 0; d < ND; d++) begin
         if (!digit_en[d])                    e[d*NC +: NC] = '0;
         else if (cursor_en && cursor_bits[d]) e[d*NC +: NC] = {NC{ph}};
         else                                  e[d*NC +: NC] = glyph(chars[d], r[2:0]);
      end
      return e;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_lit(output int r);
      forever begin
         @(negedge clk); #1;
         if (row_sel != '0) break;
      end
      r = -1;
      for (int i = 0; i < NR; i++) if (row_sel[i]) r = i;
   endtask

   task automatic wait_dark();
      forever begin
         @(negedge clk); #1;
         if (row_sel == '0) break;
      end
   endtask

   task automatic sync_last_row();
      forever begin
         @(negedge clk); #1;
         if (row_sel == 7'h40) break;
      end
   endtask

   task automatic check_frame(input string tag, output logic [ND*NC-1:0] first);
      int r;
      wait_dark();
      first = '0;
      for (int e = 0; e < NR; e++) begin
         wait_lit(r);
         chk(r == e, "R2 row order", r, e);
         chk(col_out == exp_cols(r), tag, col_out, exp_cols(r));
         if (e == 0) first = col_out;
         wait_dark();
         chk(col_out == '0, "R3 dark slot columns", col_out, 0);
      end
   endtask

   task automatic t_reset();
      int r;
      rst_n = 1'b0;
      repeat (3) begin
         @(negedge clk); #1;
         chk(row_sel == '0 && col_out == '0, "R1 in reset", {row_sel, col_out}, 0);
      end
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk); #1;
         chk(row_sel == '0 && col_out == '0, "R1 before first tick", {row_sel, col_out}, 0);
      end
      wait_lit(r);
      chk(r == 0, "R1 first row", r, 0);
   endtask

   task automatic t_timing(input int div);
      int n, m, r;
      refresh_div = PW'(div);
      wait_dark(); wait_lit(r); wait_dark();
      wait_lit(r);
      n = 1;
      forever begin @(negedge clk); #1; if (row_sel == '0) break; n++; end
      chk(n == div + 1, "R4 lit slot length", n, div + 1);
      m = 1;
      forever begin @(negedge clk); #1; if (row_sel != '0) break; m++; end
      chk(m == div + 1, "R4 dark slot length", m, div + 1);
   endtask

   task automatic t_chars();
      logic [ND*NC-1:0] f;
      sync_last_row();
      cursor_en = 1'b0; cursor_bits = 4'b1111; digit_en = 4'b1111;
      chars[0] = 7'h41; chars[1] = 7'h5A; chars[2] = 7'h33; chars[3] = 7'h7E;
      check_frame("R5 R6 characters, cursor bits ignored", f);
      sync_last_row();
      chars[0] = 7'h10; chars[1] = 7'h6C; chars[2] = 7'h07; chars[3] = 7'h2B;
      check_frame("R5 second character pattern", f);
   endtask

   task automatic t_cursor();
      logic [ND*NC-1:0] fa, fb;
      sync_last_row();
      cursor_en = 1'b1; cursor_bits = 4'b0101; digit_en = 4'b1111;
      check_frame("R7 cursor substitution", fa);
      check_frame("R7 cursor substitution next frame", fb);
      chk((fa[4:0] ^ fb[4:0]) == 5'h1F, "R8 cursor alternates per frame", {fa[4:0], fb[4:0]}, 5'h1F);
      chk((fa[14:10] ^ fb[14:10]) == 5'h1F, "R8 cursor digit 2 alternates", {fa[14:10], fb[14:10]}, 5'h1F);
   endtask

   task automatic t_blank();
      logic [ND*NC-1:0] f, c;
      int r;
      sync_last_row();
      cursor_en = 1'b0; digit_en = 4'b0110;
      check_frame("R9 blanked digits", f);
      wait_lit(r);
      c = col_out;
      digit_en[1] = 1'b0; #1;
      chk(col_out[9:5] == 5'h00, "R9 live gate off", col_out[9:5], 0);
      digit_en[1] = 1'b1; #1;
      chk(col_out == c, "R9 pattern restored", col_out, c);
      digit_en = 4'b1111;
   endtask

   task automatic t_sample();
      logic [ND*NC-1:0] c;
      int r;
      cursor_en = 1'b0; digit_en = 4'b1111;
      wait_dark();
      wait_lit(r);
      c = col_out;
      chars[1] = chars[1] ^ 7'h1F; #1;
      chk(col_out == c, "R10 lit row unchanged", col_out, c);
      wait_dark();
      wait_lit(r);
      chk(col_out == exp_cols(r), "R10 next row uses new code", col_out, exp_cols(r));
   endtask

   initial begin
      rst_n = 1'b0; refresh_div = PW'(5); cursor_en = 1'b0;
      cursor_bits = '0; digit_en = '1;
      chars[0] = 7'h20; chars[1] = 7'h20; chars[2] = 7'h20; chars[3] = 7'h20;
      t_reset();
      t_timing(5);
      t_timing(9);
      t_timing(4);
      t_chars();
      t_cursor();
      t_blank();
      t_sample();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule